// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned operands one bit per clock. It has one adder as wide as an operand and a double-width product register. A start pulse captures the multiplicand into a holding register. The same pulse clears the upper half of the product register and loads the multiplier into its lower half.

Each following cycle looks at the least significant bit of the product register. When that bit is set, the multiplicand is added into the upper half. The adder result is then shifted right together with the lower half. The adder carry-out takes the vacated top bit, and a zero enters behind it. As the product grows, the unused multiplier bits leave at the bottom of the register.

After as many iterations as the operand has bits, the full product sits in the register. It is shown as a high word and a low word. A nonzero high word tells software that the product does not fit in a single word.

Top module: `shift_add_mult`

## Requirements
- R1: While reset is high, and in the first cycle after it, busy and done are 0 and both product words are 0.
- R2: A start pulse sampled while busy is 0 is accepted. In the next cycle busy is 1, the high word is 0 and the low word equals the multiplier operand.
- R3: One iteration takes one clock. If bit 0 of the low word is 1, the multiplicand is added to the high word with a one-bit carry. The carry, the high word and the low word then shift right by one as a single vector, with 0 shifted in at the top. For example, multiplicand 1 and multiplier 3 give high word 0 and low word 0x80000001 after the first iteration.
- R4: Busy stays 1 for exactly WIDTH cycles after a start is accepted (32 by default). Done rises in the cycle in which busy falls.
- R5: Done is 1 for exactly one cycle per accepted start.
- R6: When done is 1, {high word, low word} equals the full unsigned product of the two operands. This includes the all-ones operands, where the carry bit is needed.
- R7: A start pulse sampled while busy is 1 has no effect. This holds in the final iteration cycle too. The running product and the iteration count continue unchanged.
- R8: After done, both product words keep their value until the next accepted start.
- R9: The high word is nonzero exactly when the product exceeds WIDTH bits. For example, 0x10000 times 0x10000 gives high word 1 and low word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a multiplication (taken only when idle) |
| mcand_i | input | WIDTH | Multiplicand operand |
| mplier_i | input | WIDTH | Multiplier operand |
| busy_o | output | 1 | An iteration sequence is running |
| done_o | output | 1 | One-cycle pulse: product complete |
| prod_hi_o | output | WIDTH | Most significant word of the product register |
| prod_lo_o | output | WIDTH | Least significant word of the product register |

## Verification
Two events can fall in the same cycle here, and each is handled differently. A start pulse placed on the final iteration cycle, while busy is still high, must be dropped. The bench checks that busy stays low afterwards and that the finished product is the first operation's. A start pulse placed on the done cycle must be accepted. The bench checks that the next cycle reloads the register with the new multiplier and a cleared high word, and that the new product is then correct.

// File: rtl/shift_add_mult_pkg.sv
package shift_add_mult_pkg;
  function automatic int unsigned cnt_bits(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/sam_ctrl.sv
module sam_ctrl #(
  parameter int unsigned WIDTH = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  import shift_add_mult_pkg::*;
  localparam int unsigned CNT_W = cnt_bits(WIDTH);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

  logic [CNT_W-1:0] iter_q;
  logic             busy_q;
  logic             done_q;

  assign load_o = start_i & ~busy_q;
  assign step_o = busy_q;
  assign busy_o = busy_q;
  assign done_o = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      iter_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (load_o) begin
        busy_q <= 1'b1;
        iter_q <= '0;
      end else if (busy_q) begin
        iter_q <= iter_q + 1'b1;
        if (iter_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  // Window counter measuring the length of each busy phase
  logic [CNT_W:0] run_len;
  always_ff @(posedge clk) begin
    if (rst || load_o) run_len <= '0;
    else if (busy_q)   run_len <= run_len + 1'b1;
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R5
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ($past(busy_o) && !busy_o)); // R4
  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (run_len == (CNT_W+1)'(WIDTH))); // R4
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i && iter_q != LAST) |=> (busy_o && iter_q == $past(iter_q) + 1'b1)); // R7
endmodule

// File: rtl/sam_adder.sv
module sam_adder #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] acc_i,
  input  logic [WIDTH-1:0] addend_i,
  input  logic             en_i,
  output logic [WIDTH:0]   sum_o
);
  logic [WIDTH-1:0] gated;
  assign gated = en_i ? addend_i : '0;
  assign sum_o = {1'b0, acc_i} + {1'b0, gated};
endmodule

// File: rtl/sam_datapath.sv
module sam_datapath #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [WIDTH-1:0] mcand_i,
  input  logic [WIDTH-1:0] mplier_i,
  output logic [WIDTH-1:0] hi_o,
  output logic [WIDTH-1:0] lo_o
);
  localparam int unsigned PW = 2 * WIDTH;

  logic [WIDTH-1:0] mcand_q;
  logic [PW-1:0]    prod_q;
  logic [WIDTH:0]   sum;
  logic [PW:0]      widened;

  sam_adder #(.WIDTH(WIDTH)) u_add (
    .acc_i    (prod_q[PW-1:WIDTH]),
    .addend_i (mcand_q),
    .en_i     (prod_q[0]),
    .sum_o    (sum)
  );

  assign widened = {sum, prod_q[WIDTH-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand_q <= '0;
      prod_q  <= '0;
    end else if (load_i) begin
      mcand_q <= mcand_i;
      prod_q  <= {{WIDTH{1'b0}}, mplier_i};
    end else if (step_i) begin
      prod_q  <= widened[PW:1];
    end
  end

  assign hi_o = prod_q[PW-1:WIDTH];
  assign lo_o = prod_q[WIDTH-1:0];

  AST_LOAD: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (hi_o == '0 && lo_o == $past(mplier_i))); // R2
  AST_SHIFT_NO_ADD: assert property (@(posedge clk) disable iff (rst)
    (step_i && !load_i && !lo_o[0]) |=>
      (lo_o[WIDTH-1] == $past(hi_o[0]) && hi_o == ($past(hi_o) >> 1))); // R3
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!step_i && !load_i) |=> ($stable(hi_o) && $stable(lo_o))); // R8
endmodule

// File: rtl/shift_add_mult.sv
module shift_add_mult #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [WIDTH-1:0] mcand_i,
  input  logic [WIDTH-1:0] mplier_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] prod_hi_o,
  output logic [WIDTH-1:0] prod_lo_o
);
  logic load;
  logic step;

  sam_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .load_o  (load),
    .step_o  (step),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  sam_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .load_i   (load),
    .step_i   (step),
    .mcand_i  (mcand_i),
    .mplier_i (mplier_i),
    .hi_o     (prod_hi_o),
    .lo_o     (prod_lo_o)
  );

  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> busy_o); // R2
endmodule

// File: tb/tb_shift_add_mult.sv
`timescale 1ns/1ps
module tb_shift_add_mult;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0;
  logic [W-1:0] mcand_i = '0;
  logic [W-1:0] mplier_i = '0;
  logic         busy_o, done_o;
  logic [W-1:0] prod_hi_o, prod_lo_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  shift_add_mult #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .mcand_i(mcand_i),
    .mplier_i(mplier_i), .busy_o(busy_o), .done_o(done_o),
    .prod_hi_o(prod_hi_o), .prod_lo_o(prod_lo_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    return {32'b0, a} * {32'b0, b};
  endfunction

  // Accept a start, check the load, count iterations, check done and product.
  task automatic run_mult(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
    int cyc;
    @(negedge clk);
    start_i = 1'b1; mcand_i = a; mplier_i = b;
    @(negedge clk);
    start_i = 1'b0;
    chk("R2 busy after start", 64'(busy_o), 64'd1);
    chk("R2 load", {prod_hi_o, prod_lo_o}, {32'b0, b});
    cyc = 0;
    while (!done_o && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    chk("R4 iteration count", 64'(cyc), 64'(W));
    chk("R4 busy low at done", 64'(busy_o), 64'd0);
    chk(req, {prod_hi_o, prod_lo_o}, ref_mul(a, b));
    @(negedge clk);
    chk("R5 done single cycle", 64'(done_o), 64'd0);
  endtask

  task automatic t_reset;
    chk("R1 reset busy", 64'(busy_o), 64'd0);
    chk("R1 reset done", 64'(done_o), 64'd0);
    chk("R1 reset product", {prod_hi_o, prod_lo_o}, 64'd0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", {31'b0, busy_o, prod_hi_o, prod_lo_o}, 64'd0);
  endtask

  task automatic t_first_step;
    @(negedge clk);
    start_i = 1'b1; mcand_i = 32'd1; mplier_i = 32'd3;
    @(negedge clk); start_i = 1'b0;
    @(negedge clk);
    chk("R3 first iteration", {prod_hi_o, prod_lo_o}, {32'h0, 32'h80000001});
    while (!done_o) @(negedge clk);
    chk("R6 1x3", {prod_hi_o, prod_lo_o}, 64'd3);
    @(negedge clk);
  endtask

  task automatic t_patterns;
    run_mult(32'd2, 32'd3, "R6 small 2x3");
    run_mult(32'hFFFFFFFF, 32'hFFFFFFFF, "R6 all ones with carry");
    run_mult(32'h0, 32'hDEADBEEF, "R6 zero multiplicand");
    run_mult(32'h12345678, 32'h9ABCDEF0, "R6 mixed");
    run_mult(32'h80000000, 32'h00000002, "R6 top bit");
    run_mult(32'h00010000, 32'h00010000, "R9 overflow word");
    chk("R9 high nonzero", {32'b0, prod_hi_o}, 64'd1);
    run_mult(32'h0000FFFF, 32'h00010001, "R9 fits one word");
    chk("R9 high zero", {32'b0, prod_hi_o}, 64'd0);
  endtask

  task automatic t_hold;
    logic [63:0] snap;
    run_mult(32'hCAFEF00D, 32'h00C0FFEE, "R6 before hold");
    snap = {prod_hi_o, prod_lo_o};
    mcand_i = 32'h11111111; mplier_i = 32'h22222222;
    repeat (5) @(negedge clk);
    chk("R8 hold after done", {prod_hi_o, prod_lo_o}, snap);
  endtask

  task automatic t_start_while_busy;
    logic [W-1:0] a, b;
    a = 32'h00ABCDEF; b = 32'h13579BDF;
    @(negedge clk);
    start_i = 1'b1; mcand_i = a; mplier_i = b;
    @(negedge clk); start_i = 1'b0;
    for (int n = 1; n <= W; n++) begin
      if (n == 5 || n == W) begin
        start_i = 1'b1; mcand_i = 32'hFFFFFFFF; mplier_i = 32'h7;
      end
      @(negedge clk);
      start_i = 1'b0;
      if (n < W) chk("R7 still busy", 64'(busy_o), 64'd1);
    end
    chk("R7 done on time", 64'(done_o), 64'd1);
    chk("R7 product unchanged", {prod_hi_o, prod_lo_o}, ref_mul(a, b));
    @(negedge clk);
    chk("R7 no restart", 64'(busy_o), 64'd0);
  endtask

  task automatic t_start_on_done;
    logic [W-1:0] a, b;
    @(negedge clk);
    start_i = 1'b1; mcand_i = 32'd5; mplier_i = 32'd7;
    @(negedge clk); start_i = 1'b0;
    while (!done_o) @(negedge clk);
    a = 32'h0F0F0F0F; b = 32'h0000FFFF;
    start_i = 1'b1; mcand_i = a; mplier_i = b;
    @(negedge clk); start_i = 1'b0;
    chk("R2 start on done accepted", {31'b0, busy_o, prod_hi_o, prod_lo_o},
        {31'b0, 1'b1, 32'b0, b});
    while (!done_o) @(negedge clk);
    chk("R6 after back-to-back", {prod_hi_o, prod_lo_o}, ref_mul(a, b));
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_first_step();
    t_patterns();
    t_hold();
    t_start_while_busy();
    t_start_on_done();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule